// File: doc/BRIEF.md
# Bilinear Texture Sample Unit

This block is an execution unit that turns one texture sample request into one filtered colour. A request names a pixel layout, the byte address of texel (0,0), the byte stride between rows and a sample position given in texel units as fixed-point numbers with an 8-bit fraction. The unit splits each coordinate into an integer texel index and a weight. It clamps the right and lower neighbours to the texture size and forms the byte addresses of the four surrounding texels. It reads them one at a time over a single memory read port. It then expands each texel to four 8-bit channels, blends horizontally, then vertically, and presents the colour on a response port.

Every request is visible at its start (request accepted) and at its finish (response taken). An out-of-order issue scheduler can therefore track the operation from issue to completion without knowing its internal latency. The unit holds one request at a time and accepts nothing new until its result has been taken.

Top module: `texsamp_unit`

## Requirements
- R1: After reset, reqReady is 1, rspValid is 0 and memReq is 0.
- R2: For each request exactly four reads are issued, in the order (x0,y0), (x1,y0), (x0,y1), (x1,y1). Each read address is reqBase + y*reqPitch + x*B, modulo 2^32, where B is 4 for layout code 0 and 2 for layout code 1.
- R3: Only one read is outstanding at a time: memReq is high for single cycles, and the next read waits for memRdValid. While a request is in progress reqReady is 0, and a request presented then is neither accepted nor allowed to change the result.
- R4: With integer parts xi and yi (coordinate bits [23:8]), x0 = min(xi, W-1), x1 = min(xi+1, W-1), y0 = min(yi, H-1) and y1 = min(yi+1, H-1). W and H are texWidth and texHeight, and a size of 0 is treated as 1.
- R5: Layout code 0 (4 bytes per texel): the read word holds R in bits [7:0], G in [15:8], B in [23:16] and A in [31:24].
- R6: Layout code 1 (2 bytes per texel): R, G and B come from bits [15:11], [10:5] and [4:0] of the read word. Each is widened to 8 bits by repeating its top bits below it ({r5,r5[4:2]}, {g6,g6[5:4]}, {b5,b5[4:2]}), and alpha is 255.
- R7: Per channel, with weights fx and fy (coordinate bits [7:0]), lerp(a,b,f) = (a*(256-f) + b*f + 128) >> 8. Top = lerp(t00,t10,fx), bottom = lerp(t01,t11,fx), result = lerp(top,bottom,fy).
- R8: rspColor carries R in [31:24], G in [23:16], B in [15:8] and A in [7:0]. While rspValid is 1 and rspReady is 0, rspValid stays 1 and rspColor does not change. After the response is taken, reqReady returns to 1.
- R9: With zero fractions the result equals texel (x0,y0) exactly, including at the clamped edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Sample request present |
| reqReady | output | 1 | Unit can accept a request |
| reqFmt | input | 1 | Pixel layout code: 0 = 4-byte RGBA, 1 = 2-byte 5/6/5 RGB |
| reqBase | input | 32 | Byte address of texel (0,0) |
| reqPitch | input | 16 | Bytes per texture row |
| reqX | input | 24 | X in texel units, 16 integer and 8 fraction bits |
| reqY | input | 24 | Y in texel units, 16 integer and 8 fraction bits |
| texWidth | input | 16 | Texture width in texels |
| texHeight | input | 16 | Texture height in texels |
| memReq | output | 1 | Read request, one cycle |
| memAddr | output | 32 | Byte address of the read |
| memRdValid | input | 1 | Read data valid, one cycle after memReq |
| memRdData | input | 32 | Read data, little-endian from memAddr |
| rspValid | output | 1 | Filtered colour available |
| rspReady | input | 1 | Consumer takes the colour |
| rspColor | output | 32 | Filtered RGBA colour |

## Verification
The hardest situation to reach from the ports is a sample whose neighbours fall off the texture, with non-zero weights, on the 2-byte layout, where only the clamped addresses and channel widening together give the right colour. Random stimulus draws integer positions past the texture size and sizes down to one texel. Directed cases put the sample exactly on the last column and row and use a size of zero. A separate case keeps a conflicting request on the input during a whole operation and holds the response back, so that the busy-time rejection and the stable response can be seen.

// File: rtl/texsamp_pkg.sv
package texsamp_pkg;

  typedef enum logic {
    FMT_RGBA8888 = 1'b0,
    FMT_RGB565   = 1'b1
  } texFmtE;

  // strobes from control to datapath
  typedef struct packed {
    logic       latchReq;
    logic       capTexel;
    logic [1:0] texelIdx;
    logic       loadResult;
  } dpCtrlS;

  // expand a read word to {R,G,B,A}
  function automatic logic [31:0] unpackTexel(texFmtE fmt, logic [31:0] word);
    logic [4:0] r5;
    logic [5:0] g6;
    logic [4:0] b5;
    if (fmt == FMT_RGBA8888) begin
      return {word[7:0], word[15:8], word[23:16], word[31:24]};
    end
    r5 = word[15:11];
    g6 = word[10:5];
    b5 = word[4:0];
    return {r5, r5[4:2], g6, g6[5:4], b5, b5[4:2], 8'hFF};
  endfunction

endpackage

// File: rtl/texsamp_ctrl.sv
module texsamp_ctrl
  import texsamp_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   reqValid,
  output logic   reqReady,
  output logic   memReq,
  input  logic   memRdValid,
  output logic   rspValid,
  input  logic   rspReady,
  output dpCtrlS ctrl
);

  typedef enum logic [2:0] {
    S_IDLE, S_ISSUE, S_WAIT, S_BLEND, S_DONE
  } stateE;

  stateE      stateQ;
  logic [1:0] idxQ;
  logic [2:0] fetchCntQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ    <= S_IDLE;
      idxQ      <= '0;
      fetchCntQ <= '0;
    end else begin
      case (stateQ)
        S_IDLE: if (reqValid) begin
          stateQ    <= S_ISSUE;
          idxQ      <= '0;
          fetchCntQ <= '0;
        end
        S_ISSUE: begin
          stateQ    <= S_WAIT;
          fetchCntQ <= fetchCntQ + 3'd1;
        end
        S_WAIT: if (memRdValid) begin
          if (idxQ == 2'd3) stateQ <= S_BLEND;
          else begin
            idxQ   <= idxQ + 2'd1;
            stateQ <= S_ISSUE;
          end
        end
        S_BLEND: stateQ <= S_DONE;
        S_DONE:  if (rspReady) stateQ <= S_IDLE;
        default: stateQ <= S_IDLE;
      endcase
    end
  end

  assign reqReady = (stateQ == S_IDLE);
  assign memReq   = (stateQ == S_ISSUE);
  assign rspValid = (stateQ == S_DONE);

  always_comb begin
    ctrl            = '0;
    ctrl.latchReq   = (stateQ == S_IDLE) && reqValid;
    ctrl.capTexel   = (stateQ == S_WAIT) && memRdValid;
    ctrl.texelIdx   = idxQ;
    ctrl.loadResult = (stateQ == S_BLEND);
  end

  AST_SINGLE_FETCH: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> !memReq); // R3

  AST_FOUR_FETCHES: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.loadResult |-> fetchCntQ == 3'd4); // R2

  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (memReq || rspValid) |-> !reqReady); // R3

endmodule

// File: rtl/texsamp_datapath.sv
module texsamp_datapath
  import texsamp_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int PITCH_W = 16,
  parameter int DIM_W   = 16,
  parameter int FRAC_W  = 8,
  localparam int COORD_W = DIM_W + FRAC_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpCtrlS             ctrl,
  input  logic               reqFmt,
  input  logic [ADDR_W-1:0]  reqBase,
  input  logic [PITCH_W-1:0] reqPitch,
  input  logic [COORD_W-1:0] reqX,
  input  logic [COORD_W-1:0] reqY,
  input  logic [DIM_W-1:0]   texWidth,
  input  logic [DIM_W-1:0]   texHeight,
  output logic [ADDR_W-1:0]  memAddr,
  input  logic [31:0]        memRdData,
  output logic [31:0]        rspColor
);

  localparam int LW   = FRAC_W + 9;
  localparam int ONE  = 1 << FRAC_W;
  localparam int HALF = 1 << (FRAC_W - 1);

  // returns {near, far} index clamped to dim-1
  function automatic logic [2*DIM_W-1:0] clampPair(logic [DIM_W-1:0] i, logic [DIM_W-1:0] dim);
    logic [DIM_W-1:0] lim, nearI, farI;
    logic [DIM_W:0]   nxt;
    lim   = (dim == '0) ? '0 : dim - DIM_W'(1);
    nearI = (i > lim) ? lim : i;
    nxt   = {1'b0, i} + (DIM_W+1)'(1);
    farI  = (nxt > {1'b0, lim}) ? lim : nxt[DIM_W-1:0];
    return {nearI, farI};
  endfunction

  function automatic logic [7:0] lerp(logic [7:0] a, logic [7:0] b, logic [FRAC_W-1:0] f);
    logic [LW-1:0] s;
    s = LW'(a) * (LW'(ONE) - LW'(f)) + LW'(b) * LW'(f) + LW'(HALF);
    return s[FRAC_W+7:FRAC_W];
  endfunction

  texFmtE             fmtQ;
  logic [ADDR_W-1:0]  baseQ;
  logic [PITCH_W-1:0] pitchQ;
  logic [DIM_W-1:0]   x0Q, x1Q, y0Q, y1Q;
  logic [FRAC_W-1:0]  fxQ, fyQ;
  logic [31:0]        texelQ [4];
  logic [31:0]        colorQ;
  logic [31:0]        blended;
  logic [2*DIM_W-1:0] xPair, yPair;

  assign xPair = clampPair(reqX[COORD_W-1:FRAC_W], texWidth);
  assign yPair = clampPair(reqY[COORD_W-1:FRAC_W], texHeight);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fmtQ   <= FMT_RGBA8888;
      baseQ  <= '0;
      pitchQ <= '0;
      x0Q <= '0; x1Q <= '0; y0Q <= '0; y1Q <= '0;
      fxQ <= '0; fyQ <= '0;
      for (int i = 0; i < 4; i++) texelQ[i] <= '0;
      colorQ <= '0;
    end else begin
      if (ctrl.latchReq) begin
        fmtQ   <= texFmtE'(reqFmt);
        baseQ  <= reqBase;
        pitchQ <= reqPitch;
        {x0Q, x1Q} <= xPair;
        {y0Q, y1Q} <= yPair;
        fxQ <= reqX[FRAC_W-1:0];
        fyQ <= reqY[FRAC_W-1:0];
      end
      if (ctrl.capTexel) texelQ[ctrl.texelIdx] <= unpackTexel(fmtQ, memRdData);
      if (ctrl.loadResult) colorQ <= blended;
    end
  end

  // address of the texel picked by the fetch index
  logic [DIM_W-1:0]  selX, selY;
  logic [ADDR_W-1:0] rowOff, colOff;
  assign selX   = ctrl.texelIdx[0] ? x1Q : x0Q;
  assign selY   = ctrl.texelIdx[1] ? y1Q : y0Q;
  assign rowOff = ADDR_W'(selY) * ADDR_W'(pitchQ);
  assign colOff = (fmtQ == FMT_RGB565) ? (ADDR_W'(selX) << 1) : (ADDR_W'(selX) << 2);
  assign memAddr = baseQ + rowOff + colOff;

  for (genvar c = 0; c < 4; c++) begin : g_chan
    logic [7:0] top, bot;
    assign top = lerp(texelQ[0][8*c +: 8], texelQ[1][8*c +: 8], fxQ);
    assign bot = lerp(texelQ[2][8*c +: 8], texelQ[3][8*c +: 8], fxQ);
    assign blended[8*c +: 8] = lerp(top, bot, fyQ);
  end

  assign rspColor = colorQ;

  AST_OPAQUE_565: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.loadResult && fmtQ == FMT_RGB565) |=> colorQ[7:0] == 8'hFF); // R6

  AST_CLAMP_X: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.latchReq && texWidth != '0 |=> x1Q < $past(texWidth) && x0Q <= x1Q); // R4

endmodule

// File: rtl/texsamp_unit.sv
module texsamp_unit
  import texsamp_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int PITCH_W = 16,
  parameter int DIM_W   = 16,
  parameter int FRAC_W  = 8,
  localparam int COORD_W = DIM_W + FRAC_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic               reqFmt,
  input  logic [ADDR_W-1:0]  reqBase,
  input  logic [PITCH_W-1:0] reqPitch,
  input  logic [COORD_W-1:0] reqX,
  input  logic [COORD_W-1:0] reqY,
  input  logic [DIM_W-1:0]   texWidth,
  input  logic [DIM_W-1:0]   texHeight,
  output logic               memReq,
  output logic [ADDR_W-1:0]  memAddr,
  input  logic               memRdValid,
  input  logic [31:0]        memRdData,
  output logic               rspValid,
  input  logic               rspReady,
  output logic [31:0]        rspColor
);

  dpCtrlS ctrl;

  texsamp_ctrl ctrl_i (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady),
    .memReq(memReq), .memRdValid(memRdValid),
    .rspValid(rspValid), .rspReady(rspReady),
    .ctrl(ctrl)
  );

  texsamp_datapath #(
    .ADDR_W(ADDR_W), .PITCH_W(PITCH_W), .DIM_W(DIM_W), .FRAC_W(FRAC_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .reqFmt(reqFmt), .reqBase(reqBase), .reqPitch(reqPitch),
    .reqX(reqX), .reqY(reqY),
    .texWidth(texWidth), .texHeight(texHeight),
    .memAddr(memAddr), .memRdData(memRdData),
    .rspColor(rspColor)
  );

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=> rspValid && $stable(rspColor)); // R8

endmodule

// File: tb/texsamp_unit_tb_top.sv
module texsamp_unit_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqFmt = 1'b0;
  logic [31:0] reqBase = '0;
  logic [15:0] reqPitch = '0;
  logic [23:0] reqX = '0, reqY = '0;
  logic [15:0] texWidth = 16'd1, texHeight = 16'd1;
  logic        memReq;
  logic [31:0] memAddr;
  logic        memRdValid;
  logic [31:0] memRdData;
  logic        rspValid;
  logic        rspReady = 1'b0;
  logic [31:0] rspColor;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  texsamp_unit dut_i (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady),
    .reqFmt(reqFmt), .reqBase(reqBase), .reqPitch(reqPitch),
    .reqX(reqX), .reqY(reqY),
    .texWidth(texWidth), .texHeight(texHeight),
    .memReq(memReq), .memAddr(memAddr),
    .memRdValid(memRdValid), .memRdData(memRdData),
    .rspValid(rspValid), .rspReady(rspReady), .rspColor(rspColor)
  );

  function automatic logic [31:0] memHash(logic [31:0] a);
    logic [31:0] h;
    h = (a ^ 32'hA5A5_1234) * 32'h9E37_79B1;
    return h ^ (h >> 15);
  endfunction

  // memory model: data one cycle after the request
  always @(posedge clk) begin
    if (!rstN) begin
      memRdValid <= 1'b0;
      memRdData  <= '0;
    end else begin
      memRdValid <= memReq;
      memRdData  <= memHash(memAddr);
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int lim(int v, int dim);
    int m = (dim == 0) ? 0 : dim - 1;
    return (v > m) ? m : v;
  endfunction

  function automatic logic [31:0] refTexel(bit fmt, logic [31:0] w);
    logic [7:0] r, g, b;
    if (!fmt) return {w[7:0], w[15:8], w[23:16], w[31:24]};
    r = {w[15:11], w[15:13]};
    g = {w[10:5], w[10:9]};
    b = {w[4:0], w[4:2]};
    return {r, g, b, 8'd255};
  endfunction

  function automatic int refLerp(int a, int b, int f);
    return (a * (256 - f) + b * f + 128) >> 8;
  endfunction

  function automatic logic [31:0] refAddr(bit fmt, logic [31:0] base, logic [15:0] pitch,
                                          logic [23:0] x, logic [23:0] y, int w, int h, int k);
    int xi = int'(x[23:8]);
    int yi = int'(y[23:8]);
    int xs = (k % 2 == 1) ? lim(xi + 1, w) : lim(xi, w);
    int ys = (k >= 2) ? lim(yi + 1, h) : lim(yi, h);
    return base + 32'(ys) * 32'(pitch) + 32'(xs) * (fmt ? 32'd2 : 32'd4);
  endfunction

  function automatic logic [31:0] refColor(bit fmt, logic [31:0] base, logic [15:0] pitch,
                                           logic [23:0] x, logic [23:0] y, int w, int h);
    logic [31:0] t [4];
    logic [31:0] res;
    for (int k = 0; k < 4; k++) t[k] = refTexel(fmt, memHash(refAddr(fmt, base, pitch, x, y, w, h, k)));
    for (int c = 0; c < 4; c++) begin
      int tp = refLerp(int'(t[0][8*c +: 8]), int'(t[1][8*c +: 8]), int'(x[7:0]));
      int bt = refLerp(int'(t[2][8*c +: 8]), int'(t[3][8*c +: 8]), int'(x[7:0]));
      res[8*c +: 8] = 8'(refLerp(tp, bt, int'(y[7:0])));
    end
    return res;
  endfunction

  // one request: poke keeps a conflicting request present while busy
  task automatic doSample(input bit fmt, input logic [31:0] base, input logic [15:0] pitch,
                          input logic [23:0] x, input logic [23:0] y, input int w, input int h,
                          input bit poke, input int hold, input string tag);
    logic [31:0] addrs [4];
    int n = 0;
    int guard = 0;
    logic [31:0] expC, held;
    @(negedge clk);
    reqValid = 1'b1; reqFmt = fmt; reqBase = base; reqPitch = pitch;
    reqX = x; reqY = y; texWidth = 16'(w); texHeight = 16'(h);
    @(negedge clk);
    if (poke) begin
      reqFmt = ~fmt; reqBase = base ^ 32'h0F0F_0F00; reqX = x ^ 24'h000155; reqY = y ^ 24'h0002AA;
      texWidth = 16'(w + 3); texHeight = 16'(h + 5);
    end else reqValid = 1'b0;
    while (!rspValid && guard < 100) begin
      if (memReq) begin
        if (n < 4) addrs[n] = memAddr;
        n++;
      end
      if (poke) check({tag, " R3 ready low while busy"}, 32'(reqReady), 32'd0);
      @(negedge clk);
      guard++;
    end
    reqValid = 1'b0;
    check({tag, " R2 read count"}, 32'(n), 32'd4);
    for (int k = 0; k < 4 && k < n; k++)
      check({tag, " R2 R4 read address"}, addrs[k], refAddr(fmt, base, pitch, x, y, w, h, k));
    expC = refColor(fmt, base, pitch, x, y, w, h);
    check({tag, " R7 colour"}, rspColor, expC);
    held = rspColor;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check({tag, " R8 valid held"}, 32'(rspValid), 32'd1);
      check({tag, " R8 colour held"}, rspColor, held);
    end
    rspReady = 1'b1;
    @(negedge clk);
    rspReady = 1'b0;
    check({tag, " R8 ready after take"}, {31'd0, reqReady}, 32'd1);
    check({tag, " R8 valid drops"}, {31'd0, rspValid}, 32'd0);
  endtask

  initial begin : watchdog
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    logic [31:0] w32;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reqReady", {31'd0, reqReady}, 32'd1);
    check("R1 rspValid", {31'd0, rspValid}, 32'd0);
    check("R1 memReq", {31'd0, memReq}, 32'd0);

    // R5: texel-exact sample, 4-byte layout
    doSample(1'b0, 32'h1000, 16'd256, {16'd3, 8'd0}, {16'd2, 8'd0}, 16, 16, 1'b0, 0, "R5 R9 exact");
    w32 = memHash(32'h1000 + 32'd2 * 32'd256 + 32'd12);
    check("R5 R9 byte order", rspColor, {w32[7:0], w32[15:8], w32[23:16], w32[31:24]});
    // R6: exact sample, 2-byte layout
    doSample(1'b1, 32'h2000, 16'd64, {16'd5, 8'd0}, {16'd1, 8'd0}, 32, 8, 1'b0, 1, "R6 R9 exact");
    w32 = memHash(32'h2000 + 32'd64 + 32'd10);
    check("R6 widen and alpha", rspColor,
          {w32[15:11], w32[15:13], w32[10:5], w32[10:9], w32[4:0], w32[4:2], 8'hFF});
    // R4 clamp at the last column/row with weights, both layouts
    doSample(1'b0, 32'h3000, 16'd40, {16'd9, 8'd200}, {16'd4, 8'd77}, 10, 5, 1'b0, 0, "R4 edge rgba");
    doSample(1'b1, 32'h3100, 16'd20, {16'd40, 8'd13}, {16'd90, 8'd250}, 10, 5, 1'b0, 2, "R4 beyond 565");
    // R4 zero size behaves as one texel
    doSample(1'b0, 32'h4000, 16'd4, {16'd7, 8'd128}, {16'd3, 8'd128}, 0, 0, 1'b0, 0, "R4 zero size");
    // R3 conflicting request while busy, with response held back
    doSample(1'b0, 32'h5000, 16'd128, {16'd2, 8'd64}, {16'd6, 8'd192}, 20, 20, 1'b1, 3, "R3 busy poke");
    // R7 weight extremes
    doSample(1'b0, 32'h6000, 16'd512, {16'd1, 8'd255}, {16'd1, 8'd1}, 64, 64, 1'b0, 0, "R7 extremes");

    for (int i = 0; i < 300; i++) begin
      int w = int'($urandom_range(64, 1));
      int h = int'($urandom_range(64, 1));
      bit fmt = 1'($urandom_range(1, 0));
      logic [15:0] pitch = 16'($urandom_range(1023, 0));
      logic [23:0] x = {16'($urandom_range(72, 0)), 8'($urandom)};
      logic [23:0] y = {16'($urandom_range(72, 0)), 8'($urandom)};
      doSample(fmt, $urandom, pitch, x, y, w, h, 1'($urandom_range(7, 0) == 0),
               int'($urandom_range(2, 0)), "R7 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule